// File: doc/BRIEF.md
# SDRAM Column Address Pin Mapper

This block turns a physical byte address into the column address that a memory controller drives onto its thirteen SDRAM address pins. The data bus is eight bytes wide, so the three lowest byte-address bits never reach the pins, and byte-address bit 3 always lands on pin 0. The number of column bits in a device (7 to 12) selects the mapping. Pin 10 always carries the auto-precharge request. When a device has 11 or 12 column bits, the upper column bits therefore skip over pin 10 and land on pins 11 and 12.

Each request carries a byte address, a column width and an auto-precharge flag. Requests enter on a valid/ready stream and come out one cycle later on a second valid/ready stream. Each result holds the pin pattern, a 3-bit page-size code and a flag that marks an unsupported width.

Back-pressure rules:
- A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high while the output stage is empty, or while the consumer is taking the current result in the same cycle.
- A result that is offered but not taken stays unchanged until it is taken.

Top module: `colmap_pinmap`

## Requirements
- R1: Byte-address bits [2:0] have no effect on any output.
- R2: For every supported width (7 to 12), pin 0 carries byte-address bit 3.
- R3: For width N in 7..10, pins [N-1:0] carry byte-address bits [N+2:3], pins 9 down to N are 0, and pins 11 and 12 are 0.
- R4: For every supported width, pin 10 carries the request's auto-precharge flag.
- R5: For width 11, pins [9:0] carry byte-address bits [12:3], pin 11 carries bit 13, and pin 12 is 0.
- R6: For width 12, the width-11 mapping holds and pin 12 carries byte-address bit 14.
- R7: For a supported width N, the page-size code is N-7 (0 = 1K page up to 5 = 32K page), and the invalid flag is 0.
- R8: For a width below 7 or above 12, the invalid flag is 1, the page-size code is 7 (not installed), and all thirteen pins are 0.
- R9: A request accepted while the output stage is empty or draining is offered on the output exactly one cycle later.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields hold their values.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | ADDR_W (15) | Physical byte address |
| in_colw | input | 4 | Number of column address bits |
| in_ap | input | 1 | Auto-precharge request for pin 10 |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_pins | output | PIN_W (13) | Column address pin pattern |
| out_code | output | 3 | Page-size code, 7 means not installed |
| out_inval | output | 1 | Column width unsupported |

## Verification
The assertions check the following on every cycle:
- output stability under stall;
- the one-cycle acceptance latency;
- that pin 0 and pin 10 follow the accepted request;
- that supported widths give code N-7;
- that unsupported widths give code 7 with all pins cleared.

Only the bench scenarios can show that each width routes every upper column bit to the right pin, including the jump over pin 10 at widths 11 and 12, and that the low byte-address bits never leak out. The bench also checks, under random back-pressure, that results are neither lost nor duplicated and keep their order.

// File: rtl/colmap_pkg.sv
package colmap_pkg;
  localparam int BYTE_LSBS = 3;
  localparam int COLW_W    = 4;
  localparam int CODE_W    = 3;
  localparam int CODE_MAXV = 5;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
    logic [COLW_W-1:0] ncol;
  } colcfg_t;
endpackage

// File: rtl/colmap_decode.sv
module colmap_decode
  import colmap_pkg::*;
#(
  parameter int MIN_COLS = 7,
  parameter int MAX_COLS = 12
) (
  input  logic [COLW_W-1:0] colw,
  output colcfg_t           cfg
);
  logic [COLW_W-1:0] rel;
  logic              in_range;

  assign in_range = (colw >= COLW_W'(MIN_COLS)) && (colw <= COLW_W'(MAX_COLS));
  assign rel      = colw - COLW_W'(MIN_COLS);

  always_comb begin
    cfg.ok   = in_range;
    cfg.ncol = in_range ? colw : '0;
    if (!in_range || (rel > COLW_W'(CODE_MAXV)))
      cfg.code = CODE_NONE;
    else
      cfg.code = rel[CODE_W-1:0];
  end
endmodule

// File: rtl/colmap_route.sv
module colmap_route
  import colmap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PIN_W  = 13,
  parameter int AP_PIN = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [COLW_W-1:0] ncol,
  input  logic              ap,
  input  logic              ok,
  output logic [PIN_W-1:0]  pins
);
  logic unused_lsbs;
  assign unused_lsbs = ^addr[BYTE_LSBS-1:0];

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    if (p == AP_PIN) begin : g_ap
      assign pins[p] = ok & ap;
    end else begin : g_col
      localparam int CIDX = (p < AP_PIN) ? p : p - 1;
      assign pins[p] = (ncol > COLW_W'(CIDX)) ? addr[CIDX + BYTE_LSBS] : 1'b0;
    end
  end
endmodule

// File: rtl/colmap_stage.sv
module colmap_stage #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/colmap_pinmap.sv
module colmap_pinmap
  import colmap_pkg::*;
#(
  parameter int MIN_COLS = 7,
  parameter int MAX_COLS = 12,
  parameter int AP_PIN   = 10,
  parameter int PIN_W    = MAX_COLS + 1,
  parameter int ADDR_W   = MAX_COLS + BYTE_LSBS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [COLW_W-1:0] in_colw,
  input  logic              in_ap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIN_W-1:0]  out_pins,
  output logic [CODE_W-1:0] out_code,
  output logic              out_inval
);
  localparam int DW = PIN_W + CODE_W + 1;

  colcfg_t          cfg;
  logic [PIN_W-1:0] pins_c;
  logic [DW-1:0]    res_c, res_q;

  colmap_decode #(.MIN_COLS(MIN_COLS), .MAX_COLS(MAX_COLS)) dec_i (
    .colw (in_colw),
    .cfg  (cfg)
  );

  colmap_route #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .AP_PIN(AP_PIN)) route_i (
    .addr (in_addr),
    .ncol (cfg.ncol),
    .ap   (in_ap),
    .ok   (cfg.ok),
    .pins (pins_c)
  );

  assign res_c = {pins_c, cfg.code, !cfg.ok};

  colmap_stage #(.W(DW)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign {out_pins, out_code, out_inval} = res_q;
endmodule

// File: rtl/colmap_pinmap_chk.sv
module colmap_pinmap_chk
  import colmap_pkg::*;
#(
  parameter int MIN_COLS = 7,
  parameter int MAX_COLS = 12,
  parameter int AP_PIN   = 10,
  parameter int PIN_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              addr_b3,
  input logic [COLW_W-1:0] in_colw,
  input logic              in_ap,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIN_W-1:0]  out_pins,
  input logic [CODE_W-1:0] out_code,
  input logic              out_inval
);
  logic take, take_ok;
  assign take    = in_valid && in_ready;
  assign take_ok = take && (in_colw >= COLW_W'(MIN_COLS)) && (in_colw <= COLW_W'(MAX_COLS));

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pins) && $stable(out_code) && $stable(out_inval))); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9

  AST_BAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inval) |-> (out_code == CODE_NONE && out_pins == '0)); // R8

  AST_AP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (out_pins[AP_PIN] == $past(in_ap))); // R4

  AST_PIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (out_pins[0] == $past(addr_b3))); // R2

  AST_CODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (!out_inval && out_code == CODE_W'($past(in_colw) - COLW_W'(MIN_COLS)))); // R7
endmodule

bind colmap_pinmap colmap_pinmap_chk #(
  .MIN_COLS(MIN_COLS), .MAX_COLS(MAX_COLS), .AP_PIN(AP_PIN), .PIN_W(PIN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .addr_b3(in_addr[3]), .in_colw(in_colw), .in_ap(in_ap),
  .out_valid(out_valid), .out_ready(out_ready), .out_pins(out_pins),
  .out_code(out_code), .out_inval(out_inval)
);

// File: tb/colmap_pinmap_tb_top.sv
`timescale 1ns/100ps
module colmap_pinmap_tb_top;
  localparam int AW = 15;
  localparam int PW = 13;

  typedef struct packed {
    logic [PW-1:0] pins;
    logic [2:0]    code;
    logic          inval;
    logic [3:0]    colw;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_ap = 0, out_valid, out_ready = 1, out_inval;
  logic [AW-1:0] in_addr = '0;
  logic [3:0] in_colw = '0;
  logic [PW-1:0] out_pins;
  logic [2:0] out_code;

  int checks = 0, failures = 0;
  bit done = 0;
  bit rand_ready = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  colmap_pinmap dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_colw(in_colw), .in_ap(in_ap),
    .out_valid(out_valid), .out_ready(out_ready), .out_pins(out_pins),
    .out_code(out_code), .out_inval(out_inval)
  );

  function automatic exp_t model(logic [AW-1:0] a, logic [3:0] w, logic ap);
    exp_t e;
    e = '0;
    e.colw = w;
    if (w < 7 || w > 12) begin
      e.code = 3'd7; e.inval = 1'b1;
    end else begin
      e.code = 3'(w - 7);
      for (int c = 0; c < int'(w); c++) e.pins[(c < 10) ? c : c + 1] = a[c + 3];
      e.pins[10] = ap;
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [AW-1:0] a, logic [3:0] w, logic ap);
    @(negedge clk);
    #0.5;
    in_valid = 1; in_addr = a; in_colw = w; in_ap = ap;
    while (!in_ready) begin @(negedge clk); #0.5; end
    q.push_back(model(a, w, ap));
    @(posedge clk);
    #0.1;
    in_valid = 0;
  endtask

  // monitor / scoreboard
  logic [PW+3:0] held;
  bit stalled = 0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (stalled) chk({out_pins, out_code, out_inval} == held, "R10", "stall hold",
                         int'({out_pins, out_code, out_inval}), int'(held));
        if (out_ready) begin
          stalled = 0;
          if (q.size() == 0) chk(0, "R9", "unexpected output", int'(out_pins), 0);
          else begin
            exp_t e;
            string tp;
            e = q.pop_front();
            if (e.inval) tp = "R8";
            else if (e.colw == 11) tp = "R5";
            else if (e.colw == 12) tp = "R6";
            else tp = "R3";
            chk(out_pins == e.pins, tp, "pins", int'(out_pins), int'(e.pins));
            chk(out_code == e.code && out_inval == e.inval, e.inval ? "R8" : "R7", "code/inval",
                int'({out_code, out_inval}), int'({e.code, e.inval}));
            if (!e.inval) begin
              chk(out_pins[0] == e.pins[0], "R2", "pin0", int'(out_pins[0]), int'(e.pins[0]));
              chk(out_pins[10] == e.pins[10], "R4", "pin10", int'(out_pins[10]), int'(e.pins[10]));
            end
          end
        end else begin
          stalled = 1;
          held = {out_pins, out_code, out_inval};
        end
      end else stalled = 0;
    end
  end

  // back-pressure driver
  initial begin
    forever begin
      @(negedge clk);
      out_ready = rand_ready ? $urandom_range(0, 2) != 0 : 1'b1;
    end
  end

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    @(negedge clk); #1;
    chk(out_valid == 0, "R11", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R11", "in_ready after reset", int'(in_ready), 1);

    // R9: single request appears exactly one cycle later, then disappears
    send(15'h5A5B, 4'd9, 1'b1);
    @(negedge clk); #1;
    chk(out_valid == 1, "R9", "valid one cycle after accept", int'(out_valid), 1);
    @(negedge clk); #1;
    chk(out_valid == 0, "R9", "valid drops when idle", int'(out_valid), 0);

    // every width with patterned addresses
    for (int w = 0; w < 16; w++) begin
      send(15'h7FFF, 4'(w), 1'b0);
      send(15'h2AAA, 4'(w), 1'b1);
      send(15'h5555, 4'(w), 1'b0);
    end
    // R1: only byte-address bits [2:0] differ; results must match the model, which ignores them
    send(15'h1230, 4'd12, 1'b1);
    send(15'h1237, 4'd12, 1'b1);
    send(15'h0000, 4'd7, 1'b1);
    send(15'h0007, 4'd7, 1'b1);

    // random traffic with back-pressure
    rand_ready = 1;
    for (int i = 0; i < 400; i++)
      send(AW'($urandom), 4'($urandom_range(5, 14)), 1'($urandom));
    rand_ready = 0;

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
    done = 1;
    finish_up();
  end
endmodule